// File: doc/BRIEF.md
# Oversampled Sample Block Packer

This block gathers signed conversion results from several analog channels into blocks of a configurable number of samples. A fast sample trigger captures one value from every channel at once and writes it into the next slot of the buffer being filled. A slower cycle trigger closes that block and turns it into an output record. At the same moment it captures the value of a free-running 64-bit local time counter, which is the start time of the block that begins now.

Two buffers alternate. While one holds the published record for readout, the other is filled with the next block. A record consists of four parts: the samples, which are read through a channel/index read port; the number of valid samples; the captured start time; and a record counter. Each channel also gets a 16-bit status word. It carries a toggle bit, a sync-error bit for a block that was closed early, over- and underrange flags, and a general error bit. The converter delivers one bit more than the stored width. Values outside the 16-bit signed range are saturated and flagged.

The number of samples per block is taken from `os_factor` only while the block is still empty. A change made after the first sample of a block takes effect from the next block on.

Top module: `osp_block_packer`

## Requirements
- R1: Each cycle with `sample_trig` high stores one saturated value per channel into the next free index of the block being filled. After the handover, `rd_sample` returns the value for channel `rd_ch` and index `rd_idx` in arrival order, starting at index 0.
- R2: The active block size is `os_factor`, with 0 treated as 1 and values above 64 treated as 64. Sample triggers after the block is full are dropped and change neither the stored data nor the flags.
- R3: `os_factor` is taken over only while the block being filled is empty. A change after its first sample applies from the next block on.
- R4: A cycle with `cycle_trig` high closes the block. In the next cycle `rec_valid` is 1 and `rec_fill` holds the number of stored samples. A sample trigger in the same cycle as the cycle trigger becomes index 0 of the following block and leaves the closed record unchanged.
- R5: At each handover `rec_time` captures the local time counter, which advances by one per clock. The difference between two successive records equals the number of clock cycles between their cycle triggers. `rec_time` changes only with `rec_valid`.
- R6: `rec_count` is 0 after reset and increases by one with every record, modulo 2^16.
- R7: Status bit 15 of every channel is 0 after reset and inverts with every record.
- R8: Status bit 13 is 1 when the record holds fewer samples than the active block size. Indices at or beyond `rec_fill` read as zero.
- R9: A raw value above 32767 is stored as 32767 and sets status bit 1 for that channel's record. A raw value below -32768 is stored as -32768 and sets status bit 0. In-range values are stored unchanged.
- R10: Status bit 6 is the OR of bits 1 and 0. All status bits other than 15, 13, 6, 1 and 0 are zero.
- R11: After reset `rec_valid`, `rec_count`, `rec_fill`, all status words and `rd_sample` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_trig | input | 1 | Fast trigger: capture one value per channel |
| cycle_trig | input | 1 | Cycle trigger: close block, publish record, capture time |
| os_factor | input | 7 | Requested samples per block |
| adc_raw | input | 34 | Raw 17-bit signed value per channel, channel 0 in the low bits |
| rd_ch | input | 1 | Channel selected for readout |
| rd_idx | input | 6 | Sample index selected for readout |
| rd_sample | output | 16 | Selected sample of the published record |
| rec_valid | output | 1 | One-cycle pulse after each handover |
| rec_count | output | 16 | Record counter |
| rec_time | output | 64 | Local time captured at the handover |
| rec_fill | output | 7 | Number of samples in the published record |
| rec_status | output | 32 | 16-bit status word per channel, channel 0 in the low bits |

## Verification
Two functions can fall in the same cycle: closing a block and capturing a new sample. The bench provokes this by raising `sample_trig` and `cycle_trig` on the same edge, after a block has been filled to exactly its size, with a new size requested just before. It then checks two things: the published record still holds the old samples with no sync error, and the following record holds the coincident sample at index 0 under the new size. A second coincidence, a size change arriving in the middle of a block, is judged by the record length of that block and of the next one.

// File: rtl/osp_pkg.sv
package osp_pkg;
  localparam int STAT_W      = 16;
  localparam int BIT_TOGGLE  = 15;
  localparam int BIT_SYNCERR = 13;
  localparam int BIT_ERROR   = 6;
  localparam int BIT_OVR     = 1;
  localparam int BIT_UDR     = 0;

  function automatic logic [STAT_W-1:0] make_status(input logic tog, input logic serr,
                                                     input logic ovr, input logic udr);
    logic [STAT_W-1:0] s;
    s = '0;
    s[BIT_TOGGLE]  = tog;
    s[BIT_SYNCERR] = serr;
    s[BIT_ERROR]   = ovr | udr;
    s[BIT_OVR]     = ovr;
    s[BIT_UDR]     = udr;
    return s;
  endfunction
endpackage

// File: rtl/osp_sat.sv
module osp_sat #(
  parameter int W = 16
) (
  input  logic signed [W:0] raw,
  output logic [W-1:0]      value,
  output logic              ovr,
  output logic              udr
);
  localparam logic signed [W:0] MAXV = {2'b00, {(W-1){1'b1}}};
  localparam logic signed [W:0] MINV = {2'b11, {(W-1){1'b0}}};

  always_comb begin
    ovr = raw > MAXV;
    udr = raw < MINV;
    if (ovr)      value = MAXV[W-1:0];
    else if (udr) value = MINV[W-1:0];
    else          value = raw[W-1:0];
  end

  // in-range values pass unchanged, sign included
  always_comb begin
    if (!ovr && !udr)
      assert_sat_passthru_R9: assert ($signed({value[W-1], value}) == raw)
        else $error("saturation altered an in-range value");
  end
endmodule

// File: rtl/osp_buffer.sv
module osp_buffer #(
  parameter int NUM_CH = 2,
  parameter int DEPTH  = 64,
  parameter int W      = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int FILL_W = IDX_W + 1,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [NUM_CH*W-1:0] wr_data,
  input  logic              rd_bank,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [FILL_W-1:0] rd_fill,
  output logic [W-1:0]      rd_data
);
  logic [W-1:0] ch_rd [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    logic [W-1:0] mem [2][DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_bank][wr_idx] <= wr_data[c*W +: W];
    end
    assign ch_rd[c] = mem[rd_bank][rd_idx];
  end

  always_comb begin
    if ({1'b0, rd_idx} >= rd_fill || int'(rd_ch) >= NUM_CH) rd_data = '0;
    else                                                    rd_data = ch_rd[rd_ch];
  end
endmodule

// File: rtl/osp_ctrl.sv
module osp_ctrl #(
  parameter int NUM_CH = 2,
  parameter int MAX_OS = 64,
  parameter int DEF_OS = 10,
  parameter int SEQ_W  = 16,
  parameter int TIME_W = 64,
  localparam int IDX_W  = $clog2(MAX_OS),
  localparam int FACT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_trig,
  input  logic              cycle_trig,
  input  logic [FACT_W-1:0] os_factor,
  input  logic [NUM_CH-1:0] smp_ovr,
  input  logic [NUM_CH-1:0] smp_udr,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              rd_bank,
  output logic              rec_valid,
  output logic [FACT_W-1:0] rec_fill,
  output logic              rec_serr,
  output logic              rec_tog,
  output logic [SEQ_W-1:0]  rec_cnt,
  output logic [TIME_W-1:0] rec_time,
  output logic [NUM_CH-1:0] rec_ovr,
  output logic [NUM_CH-1:0] rec_udr
);
  logic [FACT_W-1:0] fill_q, fill_d, act_q, act_d, req_f;
  logic              wbank_q;
  logic [NUM_CH-1:0] ovr_q, ovr_d, udr_q, udr_d;
  logic [TIME_W-1:0] time_q;
  logic              valid_q, serr_q, tog_q;
  logic [FACT_W-1:0] rfill_q;
  logic [SEQ_W-1:0]  cnt_q;
  logic [TIME_W-1:0] rtime_q;
  logic [NUM_CH-1:0] rovr_q, rudr_q;

  // next-state
  always_comb begin
    if (os_factor == '0)                        req_f = FACT_W'(1);
    else if (os_factor > FACT_W'(MAX_OS))       req_f = FACT_W'(MAX_OS);
    else                                        req_f = os_factor;

    wr_en   = sample_trig && (cycle_trig || fill_q < act_q);
    wr_bank = cycle_trig ? ~wbank_q : wbank_q;
    wr_idx  = cycle_trig ? '0 : fill_q[IDX_W-1:0];

    act_d = (cycle_trig || fill_q == '0) ? req_f : act_q;

    if (cycle_trig) begin
      fill_d = sample_trig ? FACT_W'(1) : '0;
      ovr_d  = sample_trig ? smp_ovr : '0;
      udr_d  = sample_trig ? smp_udr : '0;
    end else if (wr_en) begin
      fill_d = fill_q + FACT_W'(1);
      ovr_d  = ovr_q | smp_ovr;
      udr_d  = udr_q | smp_udr;
    end else begin
      fill_d = fill_q;
      ovr_d  = ovr_q;
      udr_d  = udr_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      act_q   <= FACT_W'(DEF_OS);
      wbank_q <= 1'b0;
      ovr_q   <= '0;
      udr_q   <= '0;
      time_q  <= '0;
      valid_q <= 1'b0;
      serr_q  <= 1'b0;
      tog_q   <= 1'b0;
      rfill_q <= '0;
      cnt_q   <= '0;
      rtime_q <= '0;
      rovr_q  <= '0;
      rudr_q  <= '0;
    end else begin
      fill_q  <= fill_d;
      act_q   <= act_d;
      ovr_q   <= ovr_d;
      udr_q   <= udr_d;
      time_q  <= time_q + TIME_W'(1);
      valid_q <= cycle_trig;
      if (cycle_trig) begin
        wbank_q <= ~wbank_q;
        serr_q  <= fill_q < act_q;
        tog_q   <= ~tog_q;
        rfill_q <= fill_q;
        cnt_q   <= cnt_q + SEQ_W'(1);
        rtime_q <= time_q;
        rovr_q  <= ovr_q;
        rudr_q  <= udr_q;
      end
    end
  end

  assign rd_bank   = ~wbank_q;
  assign rec_valid = valid_q;
  assign rec_fill  = rfill_q;
  assign rec_serr  = serr_q;
  assign rec_tog   = tog_q;
  assign rec_cnt   = cnt_q;
  assign rec_time  = rtime_q;
  assign rec_ovr   = rovr_q;
  assign rec_udr   = rudr_q;

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= act_q);

  assert_seq_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> cnt_q == $past(cnt_q) + SEQ_W'(1));

  assert_toggle_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> tog_q != $past(tog_q));

  assert_time_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(rtime_q));
endmodule

// File: rtl/osp_block_packer.sv
module osp_block_packer
  import osp_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 16,
  parameter int MAX_OS   = 64,
  parameter int DEF_OS   = 10,
  parameter int SEQ_W    = 16,
  parameter int TIME_W   = 64,
  localparam int IDX_W  = $clog2(MAX_OS),
  localparam int FACT_W = IDX_W + 1,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RAW_W  = SAMPLE_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_trig,
  input  logic                       cycle_trig,
  input  logic [FACT_W-1:0]          os_factor,
  input  logic [NUM_CH*RAW_W-1:0]    adc_raw,
  input  logic [CH_W-1:0]            rd_ch,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [SAMPLE_W-1:0]        rd_sample,
  output logic                       rec_valid,
  output logic [SEQ_W-1:0]           rec_count,
  output logic [TIME_W-1:0]          rec_time,
  output logic [FACT_W-1:0]          rec_fill,
  output logic [NUM_CH*STAT_W-1:0]   rec_status
);
  logic [1:0]               rst_sync_q;
  logic                     rst_int_n;
  logic [NUM_CH*SAMPLE_W-1:0] sat_data;
  logic [NUM_CH-1:0]        sat_ovr, sat_udr, rec_ovr, rec_udr;
  logic                     wr_en, wr_bank, rd_bank, rec_serr, rec_tog;
  logic [IDX_W-1:0]         wr_idx;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    osp_sat #(.W(SAMPLE_W)) i_sat (
      .raw  (adc_raw[c*RAW_W +: RAW_W]),
      .value(sat_data[c*SAMPLE_W +: SAMPLE_W]),
      .ovr  (sat_ovr[c]),
      .udr  (sat_udr[c])
    );
    assign rec_status[c*STAT_W +: STAT_W] =
      make_status(rec_tog, rec_serr, rec_ovr[c], rec_udr[c]);
  end

  osp_ctrl #(
    .NUM_CH(NUM_CH), .MAX_OS(MAX_OS), .DEF_OS(DEF_OS),
    .SEQ_W(SEQ_W), .TIME_W(TIME_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .sample_trig(sample_trig), .cycle_trig(cycle_trig), .os_factor(os_factor),
    .smp_ovr(sat_ovr), .smp_udr(sat_udr),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .rd_bank(rd_bank),
    .rec_valid(rec_valid), .rec_fill(rec_fill), .rec_serr(rec_serr),
    .rec_tog(rec_tog), .rec_cnt(rec_count), .rec_time(rec_time),
    .rec_ovr(rec_ovr), .rec_udr(rec_udr)
  );

  osp_buffer #(.NUM_CH(NUM_CH), .DEPTH(MAX_OS), .W(SAMPLE_W)) i_buf (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
    .wr_data(sat_data), .rd_bank(rd_bank), .rd_ch(rd_ch), .rd_idx(rd_idx),
    .rd_fill(rec_fill), .rd_data(rd_sample)
  );
endmodule

// File: tb/test_osp_block_packer.sv
module test_osp_block_packer;
  typedef struct packed {
    logic [6:0]         fac;
    logic [6:0]         n;
    logic signed [16:0] start;
    logic signed [16:0] step;
  } vec_t;

  // requested size, samples sent, first value, increment
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{7'd4,   7'd4,  17'sd100,     17'sd1000},   // exactly full
    '{7'd4,   7'd2,  17'sd7,       17'sd3},      // short block
    '{7'd1,   7'd1,  17'sd40000,   17'sd0},      // over / under range
    '{7'd2,   7'd3,  17'sd0,       17'sd20000},  // extra sample dropped
    '{7'd10,  7'd10, -17'sd30000,  17'sd6000},   // default size
    '{7'd64,  7'd64, -17'sd32000,  17'sd1000},   // largest size
    '{7'd0,   7'd2,  17'sd55,      17'sd1},      // 0 -> 1
    '{7'd100, 7'd3,  17'sd9,       17'sd9},      // >64 -> 64, short
    '{7'd8,   7'd0,  17'sd0,       17'sd0}       // empty block
  };

  logic        clk = 1'b0;
  logic        rst_n, sample_trig, cycle_trig;
  logic [6:0]  os_factor;
  logic [33:0] adc_raw;
  logic        rd_ch;
  logic [5:0]  rd_idx;
  logic [15:0] rd_sample;
  logic        rec_valid;
  logic [15:0] rec_count;
  logic [63:0] rec_time;
  logic [6:0]  rec_fill;
  logic [31:0] rec_status;

  always #5 clk = ~clk;

  osp_block_packer i_osp_block_packer (
    .clk(clk), .rst_n(rst_n), .sample_trig(sample_trig), .cycle_trig(cycle_trig),
    .os_factor(os_factor), .adc_raw(adc_raw), .rd_ch(rd_ch), .rd_idx(rd_idx),
    .rd_sample(rd_sample), .rec_valid(rec_valid), .rec_count(rec_count),
    .rec_time(rec_time), .rec_fill(rec_fill), .rec_status(rec_status)
  );

  int      checks = 0, miscompares = 0;
  bit      done = 0;
  longint  ecnt = 0;
  always @(posedge clk) ecnt <= ecnt + 1;

  // reference model
  int      m_eff, m_cnt;
  int      m_b0 [64];
  int      m_b1 [64];
  bit      m_o [2];
  bit      m_u [2];
  bit      exp_tog = 0;
  int      exp_cnt = 0;
  longint  prev_time, prev_edge;
  bit      have_prev = 0;

  function automatic int clampf(int f);
    if (f == 0) return 1;
    if (f > 64) return 64;
    return f;
  endfunction

  function automatic int satv(int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(string tag, string ctx, longint act, longint exp);
    checks++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, ctx, act, exp);
    end
  endtask

  task automatic model_push(int v0, int v1);
    if (m_cnt < m_eff) begin
      m_b0[m_cnt] = satv(v0);
      m_b1[m_cnt] = satv(v1);
      if (v0 > 32767)  m_o[0] = 1;
      if (v0 < -32768) m_u[0] = 1;
      if (v1 > 32767)  m_o[1] = 1;
      if (v1 < -32768) m_u[1] = 1;
      m_cnt++;
    end
  endtask

  task automatic model_clear();
    m_cnt = 0;
    for (int c = 0; c < 2; c++) begin
      m_o[c] = 0;
      m_u[c] = 0;
    end
    m_eff = clampf(int'(os_factor));
  endtask

  task automatic set_factor(int f);
    @(negedge clk);
    os_factor = 7'(f);
    if (m_cnt == 0) m_eff = clampf(f);
  endtask

  task automatic do_sample(int v0);
    @(negedge clk);
    sample_trig = 1'b1;
    adc_raw = {17'(-v0), 17'(v0)};
    @(negedge clk);
    sample_trig = 1'b0;
    model_push(v0, -v0);
  endtask

  // called at the falling edge right after the handover edge
  task automatic check_record(string fill_tag, string ctx);
    logic [15:0] st;
    int          e;
    exp_cnt++;
    exp_tog = ~exp_tog;
    chk("R4", {ctx, " rec_valid"}, longint'(rec_valid), 1);
    chk("R6", {ctx, " rec_count"}, longint'(rec_count), longint'(exp_cnt & 16'hFFFF));
    chk(fill_tag, {ctx, " rec_fill"}, longint'(rec_fill), longint'(m_cnt));
    for (int c = 0; c < 2; c++) begin
      st = rec_status[c*16 +: 16];
      chk("R7", {ctx, " toggle bit"}, longint'(st[15]), longint'(exp_tog));
      chk("R8", {ctx, " sync error bit"}, longint'(st[13]), longint'(m_cnt < m_eff));
      chk("R9", {ctx, " range bits"}, longint'(st[1:0]), longint'({m_o[c], m_u[c]}));
      chk("R10", {ctx, " error bit and zero bits"},
          longint'({st[14], st[12:7], st[6], st[5:2]}),
          longint'({1'b0, 6'b0, m_o[c] | m_u[c], 4'b0}));
    end
    if (have_prev)
      chk("R5", {ctx, " time step"}, longint'(rec_time) - prev_time, ecnt - prev_edge);
    prev_time = longint'(rec_time);
    prev_edge = ecnt;
    have_prev = 1;
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 64; i++) begin
        rd_ch  = c[0];
        rd_idx = 6'(i);
        #1;
        e = (i < m_cnt) ? ((c == 0) ? m_b0[i] : m_b1[i]) : 0;
        chk((i < m_cnt) ? "R1" : "R8", {ctx, " sample"},
            longint'(rd_sample), longint'(e & 16'hFFFF));
      end
    end
  endtask

  task automatic do_cycle(string fill_tag, string ctx);
    @(negedge clk);
    cycle_trig = 1'b1;
    @(negedge clk);
    cycle_trig = 1'b0;
    check_record(fill_tag, ctx);
    model_clear();
  endtask

  task automatic do_both(int v0, string ctx);
    @(negedge clk);
    sample_trig = 1'b1;
    cycle_trig  = 1'b1;
    adc_raw = {17'(-v0), 17'(v0)};
    @(negedge clk);
    sample_trig = 1'b0;
    cycle_trig  = 1'b0;
    check_record("R4", ctx);
    model_clear();
    model_push(v0, -v0);
  endtask

  initial begin
    rst_n = 1'b0;
    sample_trig = 1'b0;
    cycle_trig = 1'b0;
    os_factor = 7'd4;
    adc_raw = '0;
    rd_ch = 1'b0;
    rd_idx = '0;
    m_eff = 4;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11", "reset rec_valid", longint'(rec_valid), 0);
    chk("R11", "reset rec_count", longint'(rec_count), 0);
    chk("R11", "reset rec_fill", longint'(rec_fill), 0);
    chk("R11", "reset status", longint'(rec_status), 0);
    chk("R11", "reset rd_sample", longint'(rd_sample), 0);

    // vector table: R1 R2 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      set_factor(int'(VEC[v].fac));
      for (int i = 0; i < int'(VEC[v].n); i++)
        do_sample(int'(VEC[v].start) + i * int'(VEC[v].step));
      do_cycle("R2", $sformatf("vector %0d", v));
    end

    // R4: handover and capture on the same edge
    set_factor(3);
    do_sample(1);
    do_sample(2);
    do_sample(3);
    set_factor(2);
    do_both(777, "coincident old block");
    do_sample(888);
    do_cycle("R4", "coincident new block");

    // R3: size change after first sample waits for the next block
    set_factor(4);
    do_sample(5);
    set_factor(2);
    do_sample(6);
    do_sample(7);
    do_sample(8);
    do_cycle("R3", "mid-block change");
    do_sample(9);
    do_sample(10);
    do_sample(11);
    do_cycle("R3", "block after change");

    // R5: uneven spacing between handovers
    repeat (17) @(negedge clk);
    do_cycle("R5", "idle gap");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, miscompares);
      $finish;
    end
  end
endmodule